// File: doc/BRIEF.md
# Programmed-I/O Byte FIFO and Transfer Length Unit

This block holds the bytes that a host moves one at a time through a single data port of a storage-bus controller, and it works out how many bytes the next transfer-information step will move. The host pushes bytes with a write strobe and pops them with a read strobe. The FIFO is 16 entries deep but never holds more than 15 bytes. A pop raises a one-cycle interrupt pulse. When the current bus phase is a data-out phase, a pop returns zero and does not advance the read pointer. When the FIFO drains, both pointers go back to slot zero.

The second half holds a 16-bit transfer count, which is written as a low byte and a high byte. A command that carries the DMA flag copies the written bytes into a visible shadow. A transfer command then produces an effective length. A count of zero stands for 65536. The length is then limited by one of two values: 32 when the controller is collecting a command, or otherwise the magnitude of a signed pending size whose sign gives the direction. That length is latched, and a remaining-bytes counter is loaded with it and counts down once per transferred byte.

Top module: `pio_fifo_xfer`

## Requirements
- R1: After reset, fill_level, pop_data, pop_irq, tc_shadow, xfer_len and xfer_left are all zero.
- R2: A push while fill_level is below 15 stores the byte and raises fill_level by one on the next edge. A push while fill_level is 15 is dropped: the level stays 15 and the byte never appears in later pops.
- R3: A pop while fill_level is non-zero lowers the level by one and pulses pop_irq high for exactly the following cycle. When (xfer_phase & 3'b110) is non-zero, pop_data shows the oldest stored byte, and bytes leave in push order.
- R4: When (xfer_phase & 3'b110) is zero (data-out), an accepted pop sets pop_data to 8'h00 and lowers the level, but leaves the read position unchanged.
- R5: A pop while fill_level is zero is ignored: pop_data keeps its previous value, the level does not change, and pop_irq stays low.
- R6: A push and a pop in the same cycle with fill_level between 1 and 14 leave fill_level unchanged. At level 15 the push is dropped and the level falls to 14.
- R7: Whenever fill_level returns to zero, both the read and the write positions go back to slot zero. The next pushed byte is therefore the next popped byte, even after data-out pops.
- R8: cnt_wr_lo and cnt_wr_hi only record bytes. tc_shadow takes {high, low} of the recorded bytes on a cmd_valid with cmd_dma=1 and holds on every other cycle.
- R9: On cmd_valid with cmd_ti=1, xfer_len takes T (the shadow value, or the freshly copied value when cmd_dma is also 1; 0 means 65536), limited to 32 when cmd_mode=1, or else limited to |pend_size|.
- R10: xfer_left is loaded with the new xfer_len on a transfer command and then drops by one on each xfer_beat, stopping at zero. xfer_len holds its value meanwhile, and xfer_left never exceeds xfer_len.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_en | input | 1 | Host write to the data port |
| push_data | input | 8 | Byte written |
| pop_en | input | 1 | Host read of the data port |
| xfer_phase | input | 3 | Current bus phase code |
| pop_data | output | 8 | Byte returned by the last accepted pop |
| pop_irq | output | 1 | One-cycle pulse after an accepted pop |
| fill_level | output | 5 | Bytes held |
| cnt_wr_lo | input | 1 | Record cnt_wdata as count low byte |
| cnt_wr_hi | input | 1 | Record cnt_wdata as count high byte |
| cnt_wdata | input | 8 | Count byte |
| cmd_valid | input | 1 | Command strobe |
| cmd_dma | input | 1 | Command carries the DMA flag |
| cmd_ti | input | 1 | Command is a transfer-information step |
| cmd_mode | input | 1 | Controller is collecting a command |
| pend_size | input | 18 | Signed pending size (sign = direction) |
| xfer_beat | input | 1 | One byte transferred |
| tc_shadow | output | 16 | Visible copy of the transfer count |
| xfer_len | output | 17 | Effective length of the last transfer command |
| xfer_left | output | 17 | Bytes still to move |

## Verification
The hardest case to reach is a drain that follows data-out pops. Those pops leave the read position behind the write position, so only the rewind on draining brings the next pushed byte out first. Directed sequences push two bytes, pop both in a data-out phase, push a new byte and pop it in a data-in phase. Random traffic, with phases and push/pop mixes drawn from a fixed seed, keeps returning the FIFO to both empty and full while a bench model follows it. The length path is driven with a zero count, the 32-byte limit, pending sizes of both signs, and a command that copies and uses the new count in the same cycle.

// File: rtl/pio_xfer_pkg.sv
`timescale 1ns/1ps
package pio_xfer_pkg;
    // phase code bits that separate data-out from the other phases
    localparam logic [2:0] PHASE_DIR_MASK = 3'b110;

    function automatic logic phase_is_data_out(input logic [2:0] ph);
        return (ph & PHASE_DIR_MASK) == 3'b000;
    endfunction
endpackage

// File: rtl/pio_fifo_core.sv
`timescale 1ns/1ps
module pio_fifo_core #(
    parameter int DW    = 8,
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [DW-1:0]              push_data,
    input  logic                       pop,
    input  logic                       data_out_phase,
    output logic [DW-1:0]              pop_data,
    output logic                       pop_irq,
    output logic [$clog2(DEPTH):0]     level
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;
    localparam logic [CW-1:0] STOP_MARK = CW'(DEPTH - 1);

    typedef struct packed {
        logic [AW-1:0] rptr;
        logic [AW-1:0] wptr;
        logic [CW-1:0] cnt;
        logic [DW-1:0] dout;
        logic          irq;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [DW-1:0] mem_q [DEPTH];
    logic push_ok, pop_ok;

    always_comb begin
        st_d    = st_q;
        push_ok = push && (st_q.cnt != STOP_MARK);
        pop_ok  = pop && (st_q.cnt != '0);
        st_d.irq = pop_ok;
        if (pop_ok) begin
            if (data_out_phase) begin
                st_d.dout = '0;
            end else begin
                st_d.dout = mem_q[st_q.rptr];
                st_d.rptr = st_q.rptr + AW'(1);
            end
        end
        if (push_ok) begin
            st_d.wptr = st_q.wptr + AW'(1);
        end
        st_d.cnt = st_q.cnt + CW'(push_ok) - CW'(pop_ok);
        if (st_d.cnt == '0) begin
            st_d.rptr = '0;
            st_d.wptr = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem_q[st_q.wptr] <= push_data;
        end
    end

    assign pop_data = st_q.dout;
    assign pop_irq  = st_q.irq;
    assign level    = st_q.cnt;

    AST_LEVEL_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        level <= STOP_MARK); // R2
    AST_DROP_AT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && level == STOP_MARK) |=> (level == STOP_MARK)); // R2
    AST_POP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && level != '0) |=> pop_irq); // R3
    AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && level == '0) |=> ($stable(pop_data) && !pop_irq && level == '0)); // R5
    AST_BOTH_SIDES: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && level != '0 && level != STOP_MARK) |=> $stable(level)); // R6
    AST_REWIND: assert property (@(posedge clk) disable iff (!rst_n)
        (level == '0) |-> (st_q.rptr == '0 && st_q.wptr == '0)); // R7
endmodule

// File: rtl/xfer_len_calc.sv
`timescale 1ns/1ps
module xfer_len_calc #(
    parameter int TCW = 16,
    parameter int SZW = 18,
    parameter int CAP = 32
) (
    input  logic                  cmd_mode,
    input  logic [TCW-1:0]        tc,
    input  logic signed [SZW-1:0] pend,
    output logic [TCW:0]          len
);
    localparam int MW = (TCW + 1 > SZW) ? TCW + 1 : SZW;

    logic [TCW:0]   full_len;
    logic [SZW-1:0] mag;
    logic [MW-1:0]  limit;

    always_comb begin
        full_len = (tc == '0) ? {1'b1, {TCW{1'b0}}} : {1'b0, tc};
        mag      = pend[SZW-1] ? $unsigned(-pend) : $unsigned(pend);
        limit    = cmd_mode ? MW'(CAP) : MW'(mag);
        len      = (MW'(full_len) < limit) ? full_len : limit[TCW:0];
    end
endmodule

// File: rtl/xfer_remain.sv
`timescale 1ns/1ps
module xfer_remain #(
    parameter int LW = 17
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [LW-1:0] load_val,
    input  logic          beat,
    output logic [LW-1:0] len_out,
    output logic [LW-1:0] left_out
);
    typedef struct packed {
        logic [LW-1:0] len;
        logic [LW-1:0] left;
    } rem_st_t;

    rem_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.len  = load_val;
            st_d.left = load_val;
        end else if (beat && st_q.left != '0) begin
            st_d.left = st_q.left - LW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign len_out  = st_q.len;
    assign left_out = st_q.left;

    AST_LEFT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        left_out <= len_out); // R10
    AST_LEFT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (beat && !load && left_out != '0) |=> (left_out == $past(left_out) - LW'(1))); // R10
    AST_LEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(len_out)); // R10
endmodule

// File: rtl/pio_fifo_xfer.sv
`timescale 1ns/1ps
module pio_fifo_xfer
    import pio_xfer_pkg::*;
#(
    parameter int DW    = 8,
    parameter int DEPTH = 16,
    parameter int CAP   = 32,
    parameter int SZW   = 18
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  push_en,
    input  logic [DW-1:0]         push_data,
    input  logic                  pop_en,
    input  logic [2:0]            xfer_phase,
    output logic [DW-1:0]         pop_data,
    output logic                  pop_irq,
    output logic [$clog2(DEPTH):0] fill_level,
    input  logic                  cnt_wr_lo,
    input  logic                  cnt_wr_hi,
    input  logic [DW-1:0]         cnt_wdata,
    input  logic                  cmd_valid,
    input  logic                  cmd_dma,
    input  logic                  cmd_ti,
    input  logic                  cmd_mode,
    input  logic signed [SZW-1:0] pend_size,
    input  logic                  xfer_beat,
    output logic [2*DW-1:0]       tc_shadow,
    output logic [2*DW:0]         xfer_len,
    output logic [2*DW:0]         xfer_left
);
    localparam int TCW = 2 * DW;
    localparam int LW  = TCW + 1;

    typedef struct packed {
        logic [DW-1:0] wlo;
        logic [DW-1:0] whi;
        logic [DW-1:0] slo;
        logic [DW-1:0] shi;
    } cnt_st_t;

    cnt_st_t cnt_d, cnt_q;
    logic [TCW-1:0] tc_eff;
    logic [LW-1:0]  len_calc;
    logic           copy_now;

    always_comb begin
        cnt_d    = cnt_q;
        copy_now = cmd_valid && cmd_dma;
        if (cnt_wr_lo) cnt_d.wlo = cnt_wdata;
        if (cnt_wr_hi) cnt_d.whi = cnt_wdata;
        if (copy_now) begin
            cnt_d.slo = cnt_q.wlo;
            cnt_d.shi = cnt_q.whi;
        end
        tc_eff = copy_now ? {cnt_q.whi, cnt_q.wlo} : {cnt_q.shi, cnt_q.slo};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign tc_shadow = {cnt_q.shi, cnt_q.slo};

    pio_fifo_core #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
        .clk            (clk),
        .rst_n          (rst_n),
        .push           (push_en),
        .push_data      (push_data),
        .pop            (pop_en),
        .data_out_phase (phase_is_data_out(xfer_phase)),
        .pop_data       (pop_data),
        .pop_irq        (pop_irq),
        .level          (fill_level)
    );

    xfer_len_calc #(.TCW(TCW), .SZW(SZW), .CAP(CAP)) u_len (
        .cmd_mode (cmd_mode),
        .tc       (tc_eff),
        .pend     (pend_size),
        .len      (len_calc)
    );

    xfer_remain #(.LW(LW)) u_rem (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cmd_valid && cmd_ti),
        .load_val (len_calc),
        .beat     (xfer_beat),
        .len_out  (xfer_len),
        .left_out (xfer_left)
    );

    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_valid && cmd_dma) |=> $stable(tc_shadow)); // R8
    AST_LOAD_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ti) |=> (xfer_left == xfer_len)); // R10
    AST_MODE_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ti && cmd_mode) |=> (xfer_len <= LW'(CAP))); // R9
endmodule

// File: tb/pio_fifo_xfer_test.sv
`timescale 1ns/1ps
module pio_fifo_xfer_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic push_en = 0, pop_en = 0;
    logic [7:0] push_data = 0;
    logic [2:0] xfer_phase = 0;
    logic [7:0] pop_data;
    logic pop_irq;
    logic [4:0] fill_level;
    logic cnt_wr_lo = 0, cnt_wr_hi = 0;
    logic [7:0] cnt_wdata = 0;
    logic cmd_valid = 0, cmd_dma = 0, cmd_ti = 0, cmd_mode = 0;
    logic signed [17:0] pend_size = 0;
    logic xfer_beat = 0;
    logic [15:0] tc_shadow;
    logic [16:0] xfer_len, xfer_left;

    int checks = 0, failures = 0;
    bit done = 0;

    // bench model
    int m_mem [16];
    int m_rp = 0, m_wp = 0, m_cnt = 0, m_out = 0, m_irq = 0;
    int m_wlo = 0, m_whi = 0, m_slo = 0, m_shi = 0, m_len = 0, m_left = 0;

    always #5 clk = ~clk;

    pio_fifo_xfer uut (
        .clk(clk), .rst_n(rst_n), .push_en(push_en), .push_data(push_data),
        .pop_en(pop_en), .xfer_phase(xfer_phase), .pop_data(pop_data),
        .pop_irq(pop_irq), .fill_level(fill_level), .cnt_wr_lo(cnt_wr_lo),
        .cnt_wr_hi(cnt_wr_hi), .cnt_wdata(cnt_wdata), .cmd_valid(cmd_valid),
        .cmd_dma(cmd_dma), .cmd_ti(cmd_ti), .cmd_mode(cmd_mode),
        .pend_size(pend_size), .xfer_beat(xfer_beat), .tc_shadow(tc_shadow),
        .xfer_len(xfer_len), .xfer_left(xfer_left)
    );

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int exp_len(int tc, bit mode, int pend);
        int l = (tc == 0) ? 65536 : tc;
        int cap = mode ? 32 : ((pend < 0) ? -pend : pend);
        return (l < cap) ? l : cap;
    endfunction

    // one FIFO cycle: drive, clock, update model, compare
    task automatic step(string tag, bit ps, int d, bit pp, int ph);
        bit acc_push, acc_pop;
        push_en = ps; push_data = 8'(d); pop_en = pp; xfer_phase = 3'(ph);
        @(posedge clk); #1;
        acc_push = ps && (m_cnt != 15);
        acc_pop  = pp && (m_cnt != 0);
        m_irq = acc_pop;
        if (acc_pop) begin
            if ((ph & 6) == 0) m_out = 0;
            else begin m_out = m_mem[m_rp]; m_rp = (m_rp + 1) % 16; end
        end
        if (acc_push) begin m_mem[m_wp] = d & 255; m_wp = (m_wp + 1) % 16; end
        m_cnt = m_cnt + int'(acc_push) - int'(acc_pop);
        if (m_cnt == 0) begin m_rp = 0; m_wp = 0; end
        push_en = 0; pop_en = 0;
        chk(tag, "fill_level", int'(fill_level), m_cnt);
        chk(tag, "pop_data", int'(pop_data), m_out);
        chk(tag, "pop_irq", int'(pop_irq), m_irq);
    endtask

    task automatic ti_cmd(string tag, int lo, int hi, bit dma, bit ti, bit mode, int pend);
        cnt_wr_lo = 1; cnt_wdata = 8'(lo);
        @(posedge clk); #1;
        cnt_wr_lo = 0; cnt_wr_hi = 1; cnt_wdata = 8'(hi);
        @(posedge clk); #1;
        m_wlo = lo & 255; m_whi = hi & 255;
        cnt_wr_hi = 0;
        // recorded bytes alone must not reach the shadow (R8)
        chk(tag, "tc_shadow before cmd", int'(tc_shadow), m_shi * 256 + m_slo);
        cmd_valid = 1; cmd_dma = dma; cmd_ti = ti; cmd_mode = mode; pend_size = 18'(pend);
        @(posedge clk); #1;
        cmd_valid = 0; cmd_dma = 0; cmd_ti = 0;
        if (dma) begin m_slo = m_wlo; m_shi = m_whi; end
        if (ti) begin
            m_len = exp_len(m_shi * 256 + m_slo, mode, pend);
            m_left = m_len;
        end
        chk(tag, "tc_shadow", int'(tc_shadow), m_shi * 256 + m_slo);
        chk(tag, "xfer_len", int'(xfer_len), m_len);
        chk(tag, "xfer_left", int'(xfer_left), m_left);
    endtask

    task automatic beats(string tag, int n);
        for (int i = 0; i < n; i++) begin
            xfer_beat = 1;
            @(posedge clk); #1;
            if (m_left > 0) m_left--;
        end
        xfer_beat = 0;
        chk(tag, "xfer_left after beats", int'(xfer_left), m_left);
        chk(tag, "xfer_len held", int'(xfer_len), m_len);
    endtask

    initial begin
        #1_500_000;
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'h5EED_0042);
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R1 reset state
        chk("R1", "fill_level", int'(fill_level), 0);
        chk("R1", "pop_data", int'(pop_data), 0);
        chk("R1", "pop_irq", int'(pop_irq), 0);
        chk("R1", "tc_shadow", int'(tc_shadow), 0);
        chk("R1", "xfer_len", int'(xfer_len), 0);
        chk("R1", "xfer_left", int'(xfer_left), 0);

        // R5 pop on empty FIFO
        step("R5", 0, 0, 1, 7);
        // R2 fill to the cap, then overrun push is dropped
        for (int i = 0; i < 15; i++) step("R2", 1, 16 + i, 0, 7);
        step("R2", 1, 8'hEE, 0, 7);
        chk("R2", "level at cap", int'(fill_level), 15);
        // R6 push+pop at the cap: push dropped, level 14
        step("R6", 1, 8'hDD, 1, 7);
        chk("R6", "level after both at cap", int'(fill_level), 14);
        // R6 push+pop mid-range keeps level
        step("R6", 1, 8'h77, 1, 3);
        chk("R6", "level unchanged", int'(fill_level), 14);
        // R3 drain in order in a data-in phase
        for (int i = 0; i < 14; i++) step("R3", 0, 0, 1, 7);
        chk("R3", "last byte", int'(pop_data), 8'h77);
        // R5 pop on empty keeps last byte
        step("R5", 0, 0, 1, 7);
        chk("R5", "held data", int'(pop_data), 8'h77);

        // R4 data-out pop returns zero and leaves read position
        step("R4", 1, 8'hA1, 0, 7);
        step("R4", 1, 8'hA2, 0, 7);
        step("R4", 0, 0, 1, 1);
        chk("R4", "data-out byte", int'(pop_data), 0);
        step("R4", 0, 0, 1, 6);
        chk("R4", "first byte still next", int'(pop_data), 8'hA1);
        // R7 rewind after data-out drain
        step("R7", 1, 8'hB1, 0, 7);
        step("R7", 1, 8'hB2, 0, 7);
        step("R7", 0, 0, 1, 0);
        step("R7", 0, 0, 1, 0);
        chk("R7", "drained", int'(fill_level), 0);
        step("R7", 1, 8'hC3, 0, 7);
        step("R7", 0, 0, 1, 4);
        chk("R7", "new byte first", int'(pop_data), 8'hC3);

        // random traffic
        for (int i = 0; i < 600; i++) begin
            int r = $urandom_range(0, 99);
            bit ps = (i % 200 < 100) ? (r < 70) : (r < 30);
            bit pp = ($urandom_range(0, 99) < 50);
            step("R3", ps, $urandom_range(0, 255), pp, $urandom_range(0, 7));
        end

        // length path
        ti_cmd("R9", 8'h00, 8'h00, 1, 1, 0, 70000);
        chk("R9", "zero count means 65536", int'(xfer_len), 65536);
        ti_cmd("R9", 8'h05, 8'h00, 1, 1, 1, 0);
        ti_cmd("R9", 8'h00, 8'h01, 1, 1, 1, 5);
        chk("R9", "command cap", int'(xfer_len), 32);
        ti_cmd("R9", 8'h00, 8'h01, 1, 1, 0, -20);
        chk("R9", "negative pending", int'(xfer_len), 20);
        beats("R10", 7);
        beats("R10", 20);
        chk("R10", "saturated", int'(xfer_left), 0);
        ti_cmd("R9", 8'h00, 8'h01, 1, 1, 0, 300);
        ti_cmd("R8", 8'h09, 8'h00, 0, 1, 0, 300);
        chk("R8", "shadow kept old", int'(tc_shadow), 256);
        ti_cmd("R8", 8'h34, 8'h12, 1, 0, 0, 0);
        for (int i = 0; i < 30; i++) begin
            int lo = ($urandom_range(0, 3) == 0) ? 0 : $urandom_range(0, 255);
            int hi = ($urandom_range(0, 2) == 0) ? 0 : $urandom_range(0, 255);
            int pd = $urandom_range(0, 131070) - 65535;
            ti_cmd("R9", lo, hi, $urandom_range(0, 1), 1, $urandom_range(0, 1), pd);
            beats("R10", $urandom_range(0, 40));
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule